// File: doc/BRIEF.md
# MMU Control and Status Register Unit

This block is the register front end of a device-side memory management unit. Software reaches it over a simple 32-bit write/read bus with word-aligned offsets. Through it software points the translation walker at a page directory, switches translation on and off, asks the walker to stall, flushes cached translations (all of them or a single page), acknowledges page faults and reads the cause of interrupts. The walker is a separate block. It reports its busy state, page faults and bus errors back through dedicated signals.

Commands go to one command register as small codes. Two handshakes are built into the command decoder. A request to stall is refused while a page fault is pending. Stall is reported as active only once the walker has no translation in flight. A hard-reset command returns every register to its power-on value, including the directory pointer, without touching the chip reset.

The interrupt side keeps one raw bit per cause (page fault, read bus error) and a per-cause mask. A single level output is raised while any unmasked cause is pending.

Top module: `mmu_csr_unit`

## Requirements
- R1: Reads are combinational from `bus_addr`. Word offset 0x00 returns the directory pointer, 0x04 the status word, 0x0C the captured fault address, 0x14 the raw causes, 0x1C the mask, 0x20 the masked causes and 0x24 the auto-gating enable in bit 0. The other offsets (command 0x08, invalidate 0x10, clear 0x18 and any offset above 0x24) read 0. Writes to status, raw and masked status are ignored, and so is any access whose `bus_addr[1:0]` is not zero.
- R2: A write to offset 0x00 stores the data with bits 11:0 forced to zero, so writing 0xCAFEBABE reads back 0xCAFEB000. `wk_dir_base` carries the stored value.
- R3: Writing command code 0 (bits 2:0 at offset 0x08) sets status bit 0 and `wk_paging_en`, and code 1 clears them, visible after the write edge. Code 7 changes nothing.
- R4: Code 2 raises `wk_stall_req` unless status bit 1 (fault active) is set, in which case the request is ignored. Code 3 drops the request.
- R5: Status bit 2 (stall active) is set in the cycle after an edge at which the stall request stands and `wk_busy` is low. While `wk_busy` is high it stays clear. Status bit 31 always reads as the inverse of bit 2.
- R6: A `wk_fault_evt` pulse with no fault active sets status bit 1. It captures `wk_fault_addr` at offset 0x0C and `wk_fault_write` in status bit 5. Code 5 clears bit 1 and pulses `wk_fault_done` for one cycle.
- R7: Raw cause bit 0 is set by a fault event and bit 1 by `wk_bus_err`. Writing 1s at offset 0x18 clears the matching raw bits. An event in the same cycle as its clear leaves the bit set.
- R8: The masked status equals the raw causes ANDed with the mask (offset 0x1C, bits 1:0), and `irq_o` is high while any masked bit is set.
- R9: Code 4 pulses `wk_flush_all` for one cycle. A write to offset 0x10 pulses `wk_inval_one` for one cycle with `wk_inval_page` equal to the written bits 31:12.
- R10: Code 6 returns every register to its reset value: directory pointer 0, paging and stall off, no fault, raw causes, mask and gating cleared.
- R11: Status bit 3 reads as the inverse of `wk_busy` and bit 4 as `wk_replay_empty`. Bits 30:6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Level interrupt, any masked cause pending |
| wk_dir_base | output | 32 | Page directory base to the walker |
| wk_paging_en | output | 1 | Translation enabled |
| wk_stall_req | output | 1 | Stall request to the walker |
| wk_busy | input | 1 | Walker has a translation in flight |
| wk_replay_empty | input | 1 | Walker replay buffer empty |
| wk_flush_all | output | 1 | One-cycle flush of all cached translations |
| wk_inval_one | output | 1 | One-cycle single-page invalidate |
| wk_inval_page | output | 20 | Page number for the single invalidate |
| wk_fault_evt | input | 1 | Page fault event pulse |
| wk_fault_addr | input | 32 | Faulting address |
| wk_fault_write | input | 1 | Fault came from a write |
| wk_bus_err | input | 1 | Read bus error event pulse |
| wk_fault_done | output | 1 | One-cycle fault acknowledge to the walker |
| wk_autogate | output | 1 | Auto clock gating enable |

## Verification
On every cycle the assertions check four things. A directory write lands with its upper bits intact, a stall request refused during a fault leaves the request unchanged, stall is never reported active after a busy cycle, and an acknowledged fault drops. They also check that a hard reset clears the pointer and the control state, that a new cause is never lost to a same-cycle clear, and that the interrupt line never rises with an empty mask. Other behaviours are shown only by the bench scenarios. These are the exact readback of every offset and the alignment of the pointer, the one-cycle shape of the flush, invalidate and acknowledge pulses, and the page number sent with an invalidate. The same holds for the ignored writes and command code, and for the full status word after a hard reset.

// File: rtl/mmu_csr_pkg.sv
package mmu_csr_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned PAGE_W     = REG_W - PAGE_SHIFT;
  localparam int unsigned NUM_CAUSE  = 2;
  localparam int unsigned CMD_W      = 3;
  localparam int unsigned ADDR_W     = 6;
  localparam int unsigned IDX_W      = ADDR_W - 2;
  localparam int unsigned NUM_REGS   = 10;

  typedef enum logic [IDX_W-1:0] {
    RG_DIR   = 4'd0,
    RG_STAT  = 4'd1,
    RG_CMD   = 4'd2,
    RG_FADDR = 4'd3,
    RG_INVAL = 4'd4,
    RG_RAW   = 4'd5,
    RG_ICLR  = 4'd6,
    RG_IMASK = 4'd7,
    RG_ISTAT = 4'd8,
    RG_GATE  = 4'd9
  } reg_idx_e;

  typedef enum logic [CMD_W-1:0] {
    CMD_PG_ON   = 3'd0,
    CMD_PG_OFF  = 3'd1,
    CMD_STL_ON  = 3'd2,
    CMD_STL_OFF = 3'd3,
    CMD_FLUSH   = 3'd4,
    CMD_FDONE   = 3'd5,
    CMD_HRST    = 3'd6
  } cmd_e;

  // Directory pointer keeps only the page-aligned part.
  function automatic logic [REG_W-1:0] align_dir(input logic [REG_W-1:0] v);
    return {v[REG_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
  endfunction

  // New events override a clear in the same cycle.
  function automatic logic [NUM_CAUSE-1:0] cause_next(
    input logic [NUM_CAUSE-1:0] raw,
    input logic [NUM_CAUSE-1:0] clr,
    input logic [NUM_CAUSE-1:0] evt);
    return (raw & ~clr) | evt;
  endfunction

  function automatic logic [REG_W-1:0] pack_status(
    input logic paging, input logic fault, input logic stall,
    input logic idle, input logic replay_empty, input logic fault_wr);
    logic [REG_W-1:0] s;
    s = '0;
    s[0] = paging;
    s[1] = fault;
    s[2] = stall;
    s[3] = idle;
    s[4] = replay_empty;
    s[5] = fault_wr;
    s[REG_W-1] = ~stall;
    return s;
  endfunction
endpackage

// File: rtl/mmu_csr_ctrl.sv
module mmu_csr_ctrl
  import mmu_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic              dir_we,
  input  logic [REG_W-1:0]  dir_wdata,
  input  logic              gate_we,
  input  logic              gate_wdata,
  input  logic              inval_we,
  input  logic [PAGE_W-1:0] inval_wdata,
  input  logic              wk_busy,
  input  logic              wk_fault_evt,
  input  logic [REG_W-1:0]  wk_fault_addr,
  input  logic              wk_fault_write,
  output logic [REG_W-1:0]  dir_base,
  output logic              paging_en,
  output logic              stall_req,
  output logic              stall_act,
  output logic              fault_act,
  output logic [REG_W-1:0]  fault_addr,
  output logic              fault_is_wr,
  output logic              gate_en,
  output logic              flush_pulse,
  output logic              done_pulse,
  output logic              inval_pulse,
  output logic [PAGE_W-1:0] inval_page,
  output logic              hard_rst
);
  // Named command events
  logic cmd_pg_on, cmd_pg_off, cmd_stl_on, cmd_stl_off, cmd_flush, cmd_done;
  logic stall_refused, fault_take, stall_nxt;

  assign cmd_pg_on   = cmd_we && (cmd_code == CMD_PG_ON);
  assign cmd_pg_off  = cmd_we && (cmd_code == CMD_PG_OFF);
  assign cmd_stl_on  = cmd_we && (cmd_code == CMD_STL_ON);
  assign cmd_stl_off = cmd_we && (cmd_code == CMD_STL_OFF);
  assign cmd_flush   = cmd_we && (cmd_code == CMD_FLUSH);
  assign cmd_done    = cmd_we && (cmd_code == CMD_FDONE);
  assign hard_rst    = cmd_we && (cmd_code == CMD_HRST);

  assign stall_refused = cmd_stl_on && fault_act;
  assign fault_take    = wk_fault_evt && !fault_act;

  always_comb begin
    stall_nxt = stall_req;
    if (cmd_stl_on && !fault_act) stall_nxt = 1'b1;
    else if (cmd_stl_off)         stall_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_base    <= '0;
      paging_en   <= 1'b0;
      stall_req   <= 1'b0;
      stall_act   <= 1'b0;
      fault_act   <= 1'b0;
      fault_addr  <= '0;
      fault_is_wr <= 1'b0;
      gate_en     <= 1'b0;
      flush_pulse <= 1'b0;
      done_pulse  <= 1'b0;
      inval_pulse <= 1'b0;
      inval_page  <= '0;
    end else if (hard_rst) begin
      dir_base    <= '0;
      paging_en   <= 1'b0;
      stall_req   <= 1'b0;
      stall_act   <= 1'b0;
      fault_act   <= 1'b0;
      fault_addr  <= '0;
      fault_is_wr <= 1'b0;
      gate_en     <= 1'b0;
      flush_pulse <= 1'b0;
      done_pulse  <= 1'b0;
      inval_pulse <= 1'b0;
      inval_page  <= '0;
    end else begin
      if (dir_we)  dir_base <= align_dir(dir_wdata);
      if (gate_we) gate_en  <= gate_wdata;
      if (cmd_pg_on)       paging_en <= 1'b1;
      else if (cmd_pg_off) paging_en <= 1'b0;
      stall_req <= stall_nxt;
      stall_act <= stall_nxt && !wk_busy;
      if (fault_take) begin
        fault_act   <= 1'b1;
        fault_addr  <= wk_fault_addr;
        fault_is_wr <= wk_fault_write;
      end else if (cmd_done) begin
        fault_act <= 1'b0;
      end
      flush_pulse <= cmd_flush;
      done_pulse  <= cmd_done;
      inval_pulse <= inval_we;
      if (inval_we) inval_page <= inval_wdata;
    end
  end

  // R2: upper pointer bits land unchanged
  a_r2_dir_update: assert property (@(posedge clk) disable iff (!rst_n)
    dir_we |=> (dir_base[REG_W-1:PAGE_SHIFT] == $past(dir_wdata[REG_W-1:PAGE_SHIFT])));
  // R4: a refused stall leaves the request as it was
  a_r4_stall_refused: assert property (@(posedge clk) disable iff (!rst_n)
    stall_refused |=> $stable(stall_req));
  // R5: stall never reported after a busy edge
  a_r5_stall_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stall_act |-> $past(!wk_busy));
  // R6: acknowledge drops an active fault
  a_r6_fault_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && fault_act) |=> !fault_act);
  // R10: hard reset clears pointer and control state
  a_r10_hard_reset: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst |=> (dir_base == '0) && !paging_en && !stall_req && !fault_act);
endmodule

// File: rtl/mmu_csr_irq.sv
module mmu_csr_irq
  import mmu_csr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hard_rst,
  input  logic [NUM_CAUSE-1:0] evt,
  input  logic                 clr_we,
  input  logic [NUM_CAUSE-1:0] clr_bits,
  input  logic                 mask_we,
  input  logic [NUM_CAUSE-1:0] mask_bits,
  output logic [NUM_CAUSE-1:0] raw,
  output logic [NUM_CAUSE-1:0] mask,
  output logic [NUM_CAUSE-1:0] masked,
  output logic                 irq
);
  logic [NUM_CAUSE-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_bits : '0;
  assign masked  = raw & mask;
  assign irq     = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw  <= '0;
      mask <= '0;
    end else if (hard_rst) begin
      raw  <= '0;
      mask <= '0;
    end else begin
      raw <= cause_next(raw, clr_eff, evt);
      if (mask_we) mask <= mask_bits;
    end
  end

  // R7: a new cause is never lost to a clear
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((|evt) && !hard_rst) |=> ((raw & $past(evt)) == $past(evt)));
  // R8: the line only rises with some cause enabled
  a_r8_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != '0));
endmodule

// File: rtl/mmu_csr_unit.sv
module mmu_csr_unit
  import mmu_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq_o,
  output logic [REG_W-1:0]  wk_dir_base,
  output logic              wk_paging_en,
  output logic              wk_stall_req,
  input  logic              wk_busy,
  input  logic              wk_replay_empty,
  output logic              wk_flush_all,
  output logic              wk_inval_one,
  output logic [PAGE_W-1:0] wk_inval_page,
  input  logic              wk_fault_evt,
  input  logic [REG_W-1:0]  wk_fault_addr,
  input  logic              wk_fault_write,
  input  logic              wk_bus_err,
  output logic              wk_fault_done,
  output logic              wk_autogate
);
  logic [IDX_W-1:0]    idx;
  logic                aligned;
  logic [NUM_REGS-1:0] wr_sel;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_wsel
    assign wr_sel[g] = bus_wr && aligned && (idx == IDX_W'(g));
  end

  logic                 stall_act, fault_act, fault_is_wr, hard_rst;
  logic [REG_W-1:0]     fault_addr;
  logic [NUM_CAUSE-1:0] raw, mask, masked, evt;

  mmu_csr_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_we         (wr_sel[RG_CMD]),
    .cmd_code       (bus_wdata[CMD_W-1:0]),
    .dir_we         (wr_sel[RG_DIR]),
    .dir_wdata      (bus_wdata),
    .gate_we        (wr_sel[RG_GATE]),
    .gate_wdata     (bus_wdata[0]),
    .inval_we       (wr_sel[RG_INVAL]),
    .inval_wdata    (bus_wdata[REG_W-1:PAGE_SHIFT]),
    .wk_busy        (wk_busy),
    .wk_fault_evt   (wk_fault_evt),
    .wk_fault_addr  (wk_fault_addr),
    .wk_fault_write (wk_fault_write),
    .dir_base       (wk_dir_base),
    .paging_en      (wk_paging_en),
    .stall_req      (wk_stall_req),
    .stall_act      (stall_act),
    .fault_act      (fault_act),
    .fault_addr     (fault_addr),
    .fault_is_wr    (fault_is_wr),
    .gate_en        (wk_autogate),
    .flush_pulse    (wk_flush_all),
    .done_pulse     (wk_fault_done),
    .inval_pulse    (wk_inval_one),
    .inval_page     (wk_inval_page),
    .hard_rst       (hard_rst)
  );

  assign evt = {wk_bus_err, wk_fault_evt};

  mmu_csr_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hard_rst  (hard_rst),
    .evt       (evt),
    .clr_we    (wr_sel[RG_ICLR]),
    .clr_bits  (bus_wdata[NUM_CAUSE-1:0]),
    .mask_we   (wr_sel[RG_IMASK]),
    .mask_bits (bus_wdata[NUM_CAUSE-1:0]),
    .raw       (raw),
    .mask      (mask),
    .masked    (masked),
    .irq       (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (idx)
        RG_DIR:   bus_rdata = wk_dir_base;
        RG_STAT:  bus_rdata = pack_status(wk_paging_en, fault_act, stall_act,
                                          !wk_busy, wk_replay_empty, fault_is_wr);
        RG_FADDR: bus_rdata = fault_addr;
        RG_RAW:   bus_rdata = REG_W'(raw);
        RG_IMASK: bus_rdata = REG_W'(mask);
        RG_ISTAT: bus_rdata = REG_W'(masked);
        RG_GATE:  bus_rdata = REG_W'(wk_autogate);
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: tb/mmu_csr_unit_test.sv
module mmu_csr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic [31:0] wk_dir_base;
  logic        wk_paging_en, wk_stall_req;
  logic        wk_busy = 1'b0;
  logic        wk_replay_empty = 1'b1;
  logic        wk_flush_all, wk_inval_one;
  logic [19:0] wk_inval_page;
  logic        wk_fault_evt = 1'b0;
  logic [31:0] wk_fault_addr = '0;
  logic        wk_fault_write = 1'b0;
  logic        wk_bus_err = 1'b0;
  logic        wk_fault_done, wk_autogate;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mmu_csr_unit uut (.*);

  localparam logic [5:0] A_DIR = 6'h00, A_STAT = 6'h04, A_CMD = 6'h08,
    A_FADDR = 6'h0C, A_INVAL = 6'h10, A_RAW = 6'h14, A_CLR = 6'h18,
    A_MASK = 6'h1C, A_MSTAT = 6'h20, A_GATE = 6'h24;

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_STAT, v); chk("R11", "reset status", v, 32'h8000_0018);
    rd(A_DIR, v);  chk("R1", "reset dir", v, 32'h0);
    chk("R8", "reset irq", {31'b0, irq_o}, 32'h0);
    wk_busy = 1'b1; rd(A_STAT, v); chk("R11", "idle low when busy", v, 32'h8000_0010);
    wk_busy = 1'b0; wk_replay_empty = 1'b0; rd(A_STAT, v);
    chk("R11", "replay flag", v, 32'h8000_0008);
    wk_replay_empty = 1'b1;
  endtask

  task automatic t_dir;
    logic [31:0] v;
    wr(A_DIR, 32'hCAFE_BABE);
    rd(A_DIR, v); chk("R2", "dir aligned", v, 32'hCAFE_B000);
    chk("R2", "dir to walker", wk_dir_base, 32'hCAFE_B000);
    wr(6'h01, 32'h1234_5678);
    rd(A_DIR, v); chk("R1", "misaligned write ignored", v, 32'hCAFE_B000);
    rd(6'h01, v); chk("R1", "misaligned read zero", v, 32'h0);
    wr(A_GATE, 32'h1);
    rd(A_GATE, v); chk("R1", "gating readback", v, 32'h1);
    chk("R1", "gating out", {31'b0, wk_autogate}, 32'h1);
    rd(A_CMD, v); chk("R1", "command reads zero", v, 32'h0);
  endtask

  task automatic t_paging;
    logic [31:0] v;
    wr(A_CMD, 32'd0);
    rd(A_STAT, v); chk("R3", "paging on bit0", {31'b0, v[0]}, 32'h1);
    chk("R3", "paging out", {31'b0, wk_paging_en}, 32'h1);
    wr(A_CMD, 32'd7);
    rd(A_STAT, v); chk("R3", "code 7 no effect", v, 32'h8000_0019);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); chk("R1", "status write ignored", v, 32'h8000_0019);
    wr(A_CMD, 32'd1);
    chk("R3", "paging off", {31'b0, wk_paging_en}, 32'h0);
    wr(A_CMD, 32'd0);
  endtask

  task automatic t_stall;
    logic [31:0] v;
    wr(A_CMD, 32'd2);
    rd(A_STAT, v); chk("R5", "stall bit2 set", {31'b0, v[2]}, 32'h1);
    chk("R5", "bit31 clear when stalled", {31'b0, v[31]}, 32'h0);
    chk("R4", "stall request", {31'b0, wk_stall_req}, 32'h1);
    wr(A_CMD, 32'd3);
    rd(A_STAT, v); chk("R4", "stall released", {v[31], 28'b0, v[2], 2'b0}, 32'h8000_0000);
    wk_busy = 1'b1;
    wr(A_CMD, 32'd2);
    rd(A_STAT, v); chk("R5", "no stall while busy", {31'b0, v[2]}, 32'h0);
    chk("R5", "request held while busy", {31'b0, wk_stall_req}, 32'h1);
    wk_busy = 1'b0;
    @(negedge clk);
    rd(A_STAT, v); chk("R5", "stall after busy drops", {31'b0, v[2]}, 32'h1);
    wr(A_CMD, 32'd3);
  endtask

  task automatic t_fault;
    logic [31:0] v;
    @(negedge clk);
    wk_fault_evt = 1'b1; wk_fault_addr = 32'h1234_5678; wk_fault_write = 1'b1;
    @(negedge clk);
    wk_fault_evt = 1'b0; wk_fault_addr = 32'hFFFF_0000; wk_fault_write = 1'b0;
    rd(A_STAT, v); chk("R6", "fault active and write", {26'b0, v[5], 3'b0, v[1], 1'b0}, 32'h22);
    rd(A_FADDR, v); chk("R6", "fault address", v, 32'h1234_5678);
    rd(A_RAW, v); chk("R7", "raw fault cause", v, 32'h1);
    chk("R8", "masked off no irq", {31'b0, irq_o}, 32'h0);
    wr(A_CMD, 32'd2);
    chk("R4", "stall refused in fault", {31'b0, wk_stall_req}, 32'h0);
    rd(A_STAT, v); chk("R4", "no stall bit in fault", {31'b0, v[2]}, 32'h0);
    wr(A_CMD, 32'd5);
    chk("R6", "fault done pulse", {31'b0, wk_fault_done}, 32'h1);
    rd(A_STAT, v); chk("R6", "fault cleared", {31'b0, v[1]}, 32'h0);
    @(negedge clk);
    chk("R6", "fault done one cycle", {31'b0, wk_fault_done}, 32'h0);
    wr(A_CMD, 32'd2);
    chk("R4", "stall accepted after done", {31'b0, wk_stall_req}, 32'h1);
    wr(A_CMD, 32'd3);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(A_MASK, 32'h1);
    chk("R8", "irq with mask", {31'b0, irq_o}, 32'h1);
    rd(A_MSTAT, v); chk("R8", "masked status", v, 32'h1);
    @(negedge clk); wk_bus_err = 1'b1;
    @(negedge clk); wk_bus_err = 1'b0;
    rd(A_RAW, v); chk("R7", "both causes", v, 32'h3);
    rd(A_MSTAT, v); chk("R8", "masked only bit0", v, 32'h1);
    wr(A_RAW, 32'h0);
    rd(A_RAW, v); chk("R1", "raw write ignored", v, 32'h3);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h3; wk_bus_err = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; wk_bus_err = 1'b0;
    rd(A_RAW, v); chk("R7", "event wins over clear", v, 32'h2);
    chk("R8", "irq drops", {31'b0, irq_o}, 32'h0);
    wr(A_MASK, 32'h2);
    chk("R8", "irq for bus error", {31'b0, irq_o}, 32'h1);
    wr(A_CLR, 32'h2);
    rd(A_RAW, v); chk("R7", "clear bit1", v, 32'h0);
    chk("R8", "irq low after clear", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_flush_inval;
    wr(A_CMD, 32'd4);
    chk("R9", "flush pulse", {31'b0, wk_flush_all}, 32'h1);
    @(negedge clk);
    chk("R9", "flush one cycle", {31'b0, wk_flush_all}, 32'h0);
    wr(A_INVAL, 32'hABCD_E123);
    chk("R9", "inval pulse", {31'b0, wk_inval_one}, 32'h1);
    chk("R9", "inval page", {12'b0, wk_inval_page}, 32'h000A_BCDE);
    @(negedge clk);
    chk("R9", "inval one cycle", {31'b0, wk_inval_one}, 32'h0);
  endtask

  task automatic t_hard_reset;
    logic [31:0] v;
    wr(A_DIR, 32'h5555_5FFF);
    wr(A_CMD, 32'd2);
    @(negedge clk); wk_fault_evt = 1'b1; wk_fault_addr = 32'h0BAD_0000;
    @(negedge clk); wk_fault_evt = 1'b0;
    wr(A_MASK, 32'h3);
    wr(A_CMD, 32'd6);
    rd(A_DIR, v); chk("R10", "dir cleared", v, 32'h0);
    rd(A_STAT, v); chk("R10", "status at reset", v, 32'h8000_0018);
    rd(A_MASK, v); chk("R10", "mask cleared", v, 32'h0);
    rd(A_RAW, v); chk("R10", "raw cleared", v, 32'h0);
    rd(A_FADDR, v); chk("R10", "fault addr cleared", v, 32'h0);
    rd(A_GATE, v); chk("R10", "gating cleared", v, 32'h0);
    chk("R10", "stall request cleared", {31'b0, wk_stall_req}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir();
    t_paging();
    t_stall();
    t_fault();
    t_irq();
    t_flush_inval();
    t_hard_reset();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule